// File: doc/BRIEF.md
# Integer Shift Unit with Condition Flags

This block is the shift datapath of a legacy CISC integer core. Each cycle it takes an instruction word, the destination register value, a count register and an operand size. It then performs one left or right shift, arithmetic or logical, on a byte, word or long operand. The shifted value and the condition flags N, Z, V, C and X appear on registered outputs one clock later.

The shift count comes from one of two places. It is either a 3-bit immediate field in the instruction word, or the low six bits of the count register, so register counts run from 0 to 63. Counts beyond the operand width are genuine shifts that push every bit out.

A mode input selects strict overflow detection. With it on, an arithmetic left shift reports V whenever the sign bit would have changed at any step of the shift. With it off, V is always clear. Only the low bits of the destination at the chosen size are replaced; the upper bits pass through unchanged.

There is no state machine. The only state is the output register and the X flag. X keeps its old value across shifts by zero.

Top module: `shf_unit`

## Requirements
- R1: Instruction bit 3 set selects a logical shift and clear selects arithmetic. Bit 8 set selects left and clear selects right. Bit 5 set takes the count from the count register and clear takes it from the immediate field.
- R2: The immediate count is instruction bits 11:9. A field value of 0 means a count of 8.
- R3: A register count is the count register modulo 64. Counts 32 to 63 shift every operand bit out.
- R4: Size code 0 selects byte (W=8), 1 selects word (W=16), and 2 or 3 select long (W=32). The operand is the low W bits of the destination, sign-extended for an arithmetic shift and zero-extended for a logical one.
- R5: C is the last bit shifted out, taken at the W-bit boundary. A count of 0 gives C=0.
- R6: V is 0 when strict mode is off, and for every shift other than an arithmetic left shift.
- R7: In strict mode, for an arithmetic left shift with count n < W, V is 1 exactly when operand bits W-1 down to W-1-n are not all equal.
- R8: In strict mode, for an arithmetic left shift with count n >= W (up to 63), V is 1 exactly when the W-bit operand is nonzero.
- R9: A right shift fills the vacated high bits with the operand sign when arithmetic, and with zeros when logical.
- R10: N is bit W-1 of the W-bit result. Z is 1 when the W-bit result is zero.
- R11: X takes the value of C when the count is nonzero. X keeps its previous value when the count is 0.
- R12: Outputs are registered one clock after the inputs and reset to zero. Destination bits above W pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_word | input | 16 | Instruction word (bits 3, 5, 8, 11:9 decoded) |
| dst_in | input | 32 | Destination register value (operand) |
| cnt_in | input | 32 | Count register value |
| size_in | input | 2 | Operand size code |
| strict_in | input | 1 | Strict overflow detection enable |
| dst_out | output | 32 | Destination with low W bits replaced by the result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_x | output | 1 | Extend flag |

## Verification
Several rules are checked on every cycle by the assertions. V stays clear unless the shift is strict, arithmetic and left. A zero count yields C=0 and leaves X unchanged. A byte operation keeps the upper destination bits. Z and N are never both set. The exact values of the result, of C at the width boundary, and of V in its two strict regimes can only be shown by the bench sweep. That sweep compares each output against a bit-by-bit stepping model over every size, direction, kind, mode and the boundary counts 0, 1, W-1, W, W+1, 32 and 63.

// File: rtl/shf_pkg.sv
package shf_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } size_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flag_s;
endpackage

// File: rtl/shf_count.sv
module shf_count #(
    parameter int CNT_W = 6
) (
    input  logic [15:0]      op_word,
    input  logic [31:0]      cnt_reg,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero
);
    logic [2:0] imm_fld;

    always_comb begin
        imm_fld = op_word[11:9];
        if (op_word[5]) begin
            cnt = cnt_reg[CNT_W-1:0];
        end else if (imm_fld == 3'd0) begin
            cnt = CNT_W'(8);
        end else begin
            cnt = {{(CNT_W-3){1'b0}}, imm_fld};
        end
        cnt_zero = (cnt == '0);
    end
endmodule

// File: rtl/shf_narrow.sv
module shf_narrow
    import shf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int CNT_W = 6
) (
    input  logic [DW-1:0]    dst,
    input  logic [1:0]       size,
    input  logic             arith,
    output logic [DW-1:0]    uz,
    output logic [DW-1:0]    ext,
    output logic [DW-1:0]    mask,
    output logic [CNT_W-1:0] wid
);
    logic sgn;

    always_comb begin
        unique case (size_e'(size))
            SZ_BYTE: begin
                mask = DW'(32'h0000_00FF);
                wid  = CNT_W'(8);
                sgn  = dst[7];
            end
            SZ_WORD: begin
                mask = DW'(32'h0000_FFFF);
                wid  = CNT_W'(16);
                sgn  = dst[15];
            end
            default: begin
                mask = '1;
                wid  = CNT_W'(32);
                sgn  = dst[DW-1];
            end
        endcase
        uz  = dst & mask;
        ext = (arith && sgn) ? (uz | ~mask) : uz;
    end
endmodule

// File: rtl/shf_core.sv
module shf_core #(
    parameter int DW    = 32,
    parameter int CNT_W = 6
) (
    input  logic [DW-1:0]    uz,
    input  logic [DW-1:0]    ext,
    input  logic [CNT_W-1:0] wid,
    input  logic [CNT_W-1:0] cnt,
    input  logic             left,
    input  logic             arith,
    input  logic             strict,
    output logic [DW-1:0]    res,
    output logic             c,
    output logic             v
);
    localparam int LW = DW + (1 << CNT_W);
    localparam int MW = 2 * DW;

    logic [LW-1:0]      lsh;
    logic signed [DW+1:0] rsrc;
    logic signed [DW+1:0] rsh;
    logic               fill;
    logic [CNT_W:0]     cnt_p1;
    logic [CNT_W-1:0]   low_pos;
    logic [MW-1:0]      base;
    logic [MW-1:0]      win;
    logic [DW-1:0]      wmask;
    logic [DW-1:0]      fld;
    logic               v_raw;

    always_comb begin
        lsh  = LW'(uz) << cnt;
        fill = arith & ext[DW-1];
        rsrc = $signed({fill, ext, 1'b0});
        rsh  = rsrc >>> cnt;

        if (left) begin
            res = lsh[DW-1:0];
            c   = lsh[wid];
        end else begin
            res = rsh[DW:1];
            c   = rsh[0];
        end

        cnt_p1  = (CNT_W+1)'(cnt) + (CNT_W+1)'(1);
        low_pos = wid - cnt - CNT_W'(1);
        base    = (MW'(1) << cnt_p1) - MW'(1);
        win     = base << low_pos;
        wmask   = win[DW-1:0];
        fld     = uz & wmask;

        if (cnt >= wid) begin
            v_raw = (uz != '0);
        end else begin
            v_raw = (fld != '0) && (fld != wmask);
        end
        v = strict && arith && left && v_raw;
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] op_word,
    input  logic [31:0] dst_in,
    input  logic [31:0] cnt_in,
    input  logic [1:0]  size_in,
    input  logic        strict_in,
    output logic [31:0] dst_out,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c,
    output logic        flag_x
);
    logic [CNT_W-1:0]  cnt;
    logic              cnt_zero;
    logic [DATA_W-1:0] uz;
    logic [DATA_W-1:0] ext;
    logic [DATA_W-1:0] mask;
    logic [CNT_W-1:0]  wid;
    logic [DATA_W-1:0] res;
    logic              c_w;
    logic              v_w;
    logic              arith;
    logic              left;
    flag_s             fl_d;
    logic [31:0]       dst_d;
    logic              x_d;
    logic              past_ok;

    assign arith = ~op_word[3];
    assign left  = op_word[8];

    shf_count #(.CNT_W(CNT_W)) u_cnt (
        .op_word (op_word),
        .cnt_reg (cnt_in),
        .cnt     (cnt),
        .cnt_zero(cnt_zero)
    );

    shf_narrow #(.DW(DATA_W), .CNT_W(CNT_W)) u_nar (
        .dst  (dst_in),
        .size (size_in),
        .arith(arith),
        .uz   (uz),
        .ext  (ext),
        .mask (mask),
        .wid  (wid)
    );

    shf_core #(.DW(DATA_W), .CNT_W(CNT_W)) u_core (
        .uz    (uz),
        .ext   (ext),
        .wid   (wid),
        .cnt   (cnt),
        .left  (left),
        .arith (arith),
        .strict(strict_in),
        .res   (res),
        .c     (c_w),
        .v     (v_w)
    );

    always_comb begin
        dst_d  = (dst_in & ~mask) | (res & mask);
        fl_d.n = res[wid - CNT_W'(1)];
        fl_d.z = ((res & mask) == '0);
        fl_d.v = v_w;
        fl_d.c = c_w;
        x_d    = cnt_zero ? flag_x : c_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_out <= '0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
            flag_v  <= 1'b0;
            flag_c  <= 1'b0;
            flag_x  <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            dst_out <= dst_d;
            flag_n  <= fl_d.n;
            flag_z  <= fl_d.z;
            flag_v  <= fl_d.v;
            flag_c  <= fl_d.c;
            flag_x  <= x_d;
            past_ok <= 1'b1;
        end
    end

    // R6: overflow clear outside strict arithmetic left shifts
    p_v_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!strict_in || op_word[3] || !op_word[8]) |-> !flag_v);

    // R5: zero count gives clear carry
    p_c_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cnt_zero) |-> !flag_c);

    // R11: zero count holds extend flag
    p_x_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cnt_zero) |-> flag_x == $past(flag_x));

    // R12: byte operation keeps upper destination bits
    p_upper_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(size_in) == 2'd0 |-> dst_out[31:8] == $past(dst_in[31:8]));

    // R10: zero and negative are exclusive
    p_nz_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_n);
endmodule

// File: tb/sim_shf_unit.sv
module sim_shf_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_word = '0;
    logic [31:0] dst_in = '0;
    logic [31:0] cnt_in = '0;
    logic [1:0]  size_in = '0;
    logic        strict_in = 1'b0;
    logic [31:0] dst_out;
    logic        flag_n, flag_z, flag_v, flag_c, flag_x;

    int checks = 0;
    int errors = 0;
    logic x_exp = 1'b0;

    always #5 clk = ~clk;

    shf_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_word(op_word), .dst_in(dst_in),
        .cnt_in(cnt_in), .size_in(size_in), .strict_in(strict_in),
        .dst_out(dst_out), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .flag_x(flag_x)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input bit use_reg, input int cnt, input bit logical,
                          input bit left, input int size, input bit strict,
                          input logic [31:0] dst);
        int w, n;
        logic [31:0] msk, val, res_e;
        logic c_e, v_e, sign0, fillb;
        string rtag, vtag;
        w   = (size == 0) ? 8 : (size == 1) ? 16 : 32;
        msk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        n   = use_reg ? (cnt % 64) : ((cnt == 0) ? 8 : cnt);
        val = dst & msk;
        sign0 = val[w-1];
        fillb = sign0 & ~logical;
        c_e = 1'b0;
        v_e = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (left) begin
                c_e = val[w-1];
                val = (val << 1) & msk;
                if (val[w-1] != sign0) v_e = 1'b1;
            end else begin
                c_e = val[0];
                val = (val >> 1) | (fillb ? (32'd1 << (w-1)) : 32'd0);
            end
        end
        if (!(strict && !logical && left)) v_e = 1'b0;
        res_e = (dst & ~msk) | val;
        if (n != 0) x_exp = c_e;

        @(negedge clk);
        op_word = '0;
        op_word[3] = logical;
        op_word[8] = left;
        op_word[5] = use_reg;
        op_word[11:9] = use_reg ? 3'd5 : 3'(cnt);
        cnt_in  = use_reg ? (32'hABCD_EFC0 | 32'(cnt)) : 32'h0000_0003;
        size_in = 2'(size);
        strict_in = strict;
        dst_in  = dst;
        @(negedge clk);

        if (!use_reg) rtag = "R2";
        else if (n >= 32) rtag = "R3";
        else if (size != 2 && !logical) rtag = "R4";
        else if (!left) rtag = "R9";
        else rtag = "R1";
        chk({rtag, " result"}, dst_out & msk, val);
        chk("R12 upper bits", dst_out & ~msk, dst & ~msk);
        chk("R5 carry", 32'(flag_c), 32'(c_e));
        if (!strict || logical || !left) vtag = "R6";
        else if (n < w) vtag = "R7";
        else vtag = "R8";
        chk({vtag, " overflow"}, 32'(flag_v), 32'(v_e));
        chk("R10 N", 32'(flag_n), 32'(val[w-1]));
        chk("R10 Z", 32'(flag_z), 32'(val == 0));
        chk("R11 X", 32'(flag_x), 32'(x_exp));
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pats [8];
        int cl [7];
        int w;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_8080; pats[3] = 32'h1234_5678;
        pats[4] = 32'h4000_4040; pats[5] = 32'h0000_0001;
        pats[6] = 32'h7FFF_7F7F; pats[7] = 32'hA5C3_96E1;
        repeat (3) @(negedge clk);
        chk("R12 reset dst", dst_out, 32'h0);
        chk("R12 reset flags", {27'h0, flag_n, flag_z, flag_v, flag_c, flag_x}, 32'h0);
        rst_n = 1'b1;
        for (int sz = 0; sz < 3; sz++) begin
            w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
            cl[0] = 0; cl[1] = 1; cl[2] = w - 1; cl[3] = w;
            cl[4] = w + 1; cl[5] = 32; cl[6] = 63;
            for (int dir = 0; dir < 2; dir++)
                for (int lg = 0; lg < 2; lg++)
                    for (int st = 0; st < 2; st++)
                        for (int p = 0; p < 8; p++) begin
                            for (int k = 0; k < 7; k++)
                                run_op(1'b1, cl[k], lg[0], dir[0], sz, st[0], pats[p]);
                            for (int im = 0; im < 8; im++)
                                run_op(1'b0, im, lg[0], dir[0], sz, st[0], pats[p]);
                        end
        end
        run_op(1'b1, 0, 1'b0, 1'b1, 3, 1'b1, 32'h8000_0000);
        run_op(1'b1, 1, 1'b0, 1'b1, 3, 1'b1, 32'h8000_0000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule